// File: doc/BRIEF.md
# Interrupt Remap Entry Fetcher

This block looks up one entry of an interrupt remapping table on behalf of an incoming message-signalled interrupt. On a start pulse it takes the table root from a device-table word and the entry index from the low bits of the message data, and forms the entry address. It issues a single read request on a simple memory request/response port. It then checks the returned entry and produces either a decoded interrupt (delivery type, vector, destination mode, redirection hint, destination) or one of three failure statuses.

Two entry formats are supported, selected by a global mode input that is sampled at start:
- a compact 32-bit entry, delivered in one response beat;
- an extended 128-bit entry, delivered as two 64-bit beats, the low half first.

The device-table lookup that supplies the root word, and the re-encoding of the decoded result into a message, both belong to neighbouring logic.

Top module: `irq_remap_fetch`

## Requirements
- R1: After reset, `busy`, `done` and `req_valid` are 0, `status` is 0 and every decoded field output is 0.
- R2: The request address is the table base plus the scaled index. The table base is `dte_word` with bits [51:6] kept and all other bits cleared. The index is `msg_data[10:0]`, scaled by 4 in compact mode and by 16 in extended mode. The address is truncated to 52 bits. `req_ext` equals the sampled mode.
- R3: A start accepted in idle raises `req_valid` for exactly one cycle, in the cycle after start. `busy` is high from that cycle until the cycle in which the final response beat arrives. `done` pulses for one cycle, in the cycle after the final beat, and `busy` is low in that cycle.
- R4: The compact entry sits in `rsp_data[31:0]` with this layout: valid bit [0], interrupt type [4:2], redirection hint [5], destination mode [6], guest bit [7], destination [15:8], vector [23:16]. On success the status is 0 (OK) and the fields are output; the destination is zero-extended to 24 bits.
- R5: In extended mode the first beat is the low half and the second is the high half. The low half uses the compact layout for bits [7:0], with a 24-bit destination in [31:8]. The vector comes from bits [7:0] of the high half. `done` does not rise before the second beat.
- R6: An entry whose valid bit is 0 yields status 1 (target abort). This takes priority over the guest and type checks.
- R7: A valid entry with the guest bit set yields status 2 (error).
- R8: A valid entry with guest bit 0 and interrupt type greater than 1 yields status 2 (error). Type values 0 (fixed) and 1 (arbitrated) are accepted.
- R9: A response beat with `rsp_err` set ends the response, either beat, and yields status 3 (fetch error).
- R10: A start while `busy` is high is ignored: no second request and no change to the result.
- R11: The mode, the root word and the message data are sampled at the accepted start. Later changes to them do not affect the request or the result.
- R12: When the status is not 0, every decoded field output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 1 selects the 128-bit entry format |
| start | input | 1 | Start a lookup (single-cycle pulse) |
| dte_word | input | 64 | Device-table word holding the table root |
| msg_data | input | 32 | Incoming message data; low bits index the table |
| busy | output | 1 | Lookup in progress |
| req_valid | output | 1 | Memory read request strobe |
| req_addr | output | 52 | Byte address of the entry |
| req_ext | output | 1 | 1: two 64-bit beats requested; 0: one 32-bit beat |
| rsp_valid | input | 1 | Response beat valid |
| rsp_data | input | 64 | Response beat data |
| rsp_err | input | 1 | Response beat carries a read failure |
| done | output | 1 | Result valid for one cycle |
| status | output | 2 | 0 OK, 1 target abort, 2 error, 3 fetch error |
| int_type | output | 3 | Delivery mode from the entry |
| vector | output | 8 | Interrupt vector |
| dest_mode | output | 1 | Destination mode |
| redir_hint | output | 1 | Redirection hint |
| dest | output | 24 | Destination |

## Verification
A corrupted format flag or captured low half shows up at the very next `done`. The symptom is a wrong vector or destination field, or a `done` that arrives one beat early or late. A stuck or skipped controller state shows as a missing or repeated `req_valid` pulse within two cycles of start, or as `busy` not falling on the final beat. A latched address that follows live inputs is exposed by changing the mode and data after start, which alters the result seen at `done`.

// File: rtl/irq_remap_pkg.sv
package irq_remap_pkg;

  localparam int unsigned VEC_W  = 8;
  localparam int unsigned DEST_W = 24;
  localparam int unsigned TYPE_W = 3;

  typedef enum logic [1:0] {
    RS_OK    = 2'd0,
    RS_ABORT = 2'd1,
    RS_ERR   = 2'd2,
    RS_FETCH = 2'd3
  } rmp_status_e;

  typedef enum logic [1:0] {
    FS_IDLE    = 2'd0,
    FS_ISSUE   = 2'd1,
    FS_WAIT_LO = 2'd2,
    FS_WAIT_HI = 2'd3
  } rmp_state_e;

  typedef struct packed {
    logic [TYPE_W-1:0] int_type;
    logic [VEC_W-1:0]  vector;
    logic              dest_mode;
    logic              redir_hint;
    logic [DEST_W-1:0] dest;
  } rmp_fields_t;

endpackage

// File: rtl/irq_remap_addr.sv
module irq_remap_addr #(
  parameter int unsigned PA_W     = 52,
  parameter int unsigned BASE_LSB = 6,
  parameter int unsigned IDX_W    = 11
) (
  input  logic [63:0]     dte_word,
  input  logic [31:0]     msg_data,
  input  logic            ext_mode,
  output logic [PA_W-1:0] entry_addr
);

  localparam int unsigned SH_CMP = 2;
  localparam int unsigned SH_EXT = 4;

  logic [PA_W-1:0]  base;
  logic [PA_W-1:0]  idx_w;
  logic [PA_W-1:0]  offset;
  logic             unused_bits;

  always_comb begin
    base = '0;
    base[PA_W-1:BASE_LSB] = dte_word[PA_W-1:BASE_LSB];
    idx_w = '0;
    idx_w[IDX_W-1:0] = msg_data[IDX_W-1:0];
    offset = ext_mode ? (idx_w << SH_EXT) : (idx_w << SH_CMP);
    entry_addr = base + offset;
  end

  assign unused_bits = ^{dte_word[63:PA_W], dte_word[BASE_LSB-1:0], msg_data[31:IDX_W]};

endmodule

// File: rtl/irq_remap_decode.sv
module irq_remap_decode
  import irq_remap_pkg::*;
(
  input  logic        ext_mode,
  input  logic [63:0] lo_half,
  input  logic [63:0] hi_half,
  output rmp_status_e dec_status,
  output rmp_fields_t dec_fields
);

  localparam int unsigned CMP_DEST_W = 8;
  localparam logic [TYPE_W-1:0] TYPE_MAX = 3'd1;

  logic        ent_valid;
  logic        ent_guest;
  rmp_fields_t raw;
  logic        unused_bits;

  always_comb begin
    ent_valid      = lo_half[0];
    ent_guest      = lo_half[7];
    raw            = '0;
    raw.int_type   = lo_half[4:2];
    raw.redir_hint = lo_half[5];
    raw.dest_mode  = lo_half[6];
    if (ext_mode) begin
      raw.dest   = lo_half[8 +: DEST_W];
      raw.vector = hi_half[VEC_W-1:0];
    end else begin
      raw.dest[CMP_DEST_W-1:0] = lo_half[8 +: CMP_DEST_W];
      raw.vector               = lo_half[16 +: VEC_W];
    end

    if (!ent_valid) begin
      dec_status = RS_ABORT;
    end else if (ent_guest) begin
      dec_status = RS_ERR;
    end else if (raw.int_type > TYPE_MAX) begin
      dec_status = RS_ERR;
    end else begin
      dec_status = RS_OK;
    end
    dec_fields = (dec_status == RS_OK) ? raw : '0;
  end

  assign unused_bits = ^{lo_half[63:32], lo_half[1], hi_half[63:VEC_W]};

endmodule

// File: rtl/irq_remap_ctrl.sv
module irq_remap_ctrl
  import irq_remap_pkg::*;
#(
  parameter int unsigned PA_W = 52
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            ext_mode,
  input  logic [PA_W-1:0] addr_in,
  output logic            busy,
  output logic            req_valid,
  output logic [PA_W-1:0] req_addr,
  output logic            req_ext,
  input  logic            rsp_valid,
  input  logic [63:0]     rsp_data,
  input  logic            rsp_err,
  output logic            dec_ext,
  output logic [63:0]     dec_lo,
  output logic [63:0]     dec_hi,
  input  rmp_status_e     dec_status,
  input  rmp_fields_t     dec_fields,
  output logic            done,
  output rmp_status_e     res_status,
  output rmp_fields_t     res_fields
);

  rmp_state_e      state_q, state_d;
  logic            ext_q;
  logic [PA_W-1:0] addr_q;
  logic [63:0]     lo_q;
  logic            done_q;
  rmp_status_e     status_q, status_d;
  rmp_fields_t     fields_q, fields_d;
  logic            cfg_en, lo_en, res_en;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cfg_en   = 1'b0;
    lo_en    = 1'b0;
    res_en   = 1'b0;
    status_d = dec_status;
    fields_d = dec_fields;
    unique case (state_q)
      FS_IDLE: begin
        if (start) begin
          cfg_en  = 1'b1;
          state_d = FS_ISSUE;
        end
      end
      FS_ISSUE: state_d = FS_WAIT_LO;
      FS_WAIT_LO: begin
        if (rsp_valid) begin
          if (rsp_err || !ext_q) begin
            res_en  = 1'b1;
            state_d = FS_IDLE;
          end else begin
            lo_en   = 1'b1;
            state_d = FS_WAIT_HI;
          end
        end
      end
      FS_WAIT_HI: begin
        if (rsp_valid) begin
          res_en  = 1'b1;
          state_d = FS_IDLE;
        end
      end
      default: state_d = FS_IDLE;
    endcase
    if (rsp_err) begin
      status_d = RS_FETCH;
      fields_d = '0;
    end
  end

  // decoder input selection
  always_comb begin
    dec_ext = ext_q;
    if (state_q == FS_WAIT_HI) begin
      dec_lo = lo_q;
      dec_hi = rsp_data;
    end else begin
      dec_lo = ext_q ? rsp_data : {32'd0, rsp_data[31:0]};
      dec_hi = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= FS_IDLE;
      ext_q    <= 1'b0;
      addr_q   <= '0;
      lo_q     <= '0;
      done_q   <= 1'b0;
      status_q <= RS_OK;
      fields_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= res_en;
      if (cfg_en) begin
        ext_q  <= ext_mode;
        addr_q <= addr_in;
      end
      if (lo_en) begin
        lo_q <= rsp_data;
      end
      if (res_en) begin
        status_q <= status_d;
        fields_q <= fields_d;
      end
    end
  end

  assign busy       = (state_q != FS_IDLE);
  assign req_valid  = (state_q == FS_ISSUE);
  assign req_addr   = addr_q;
  assign req_ext    = ext_q;
  assign done       = done_q;
  assign res_status = status_q;
  assign res_fields = fields_q;

  a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r9_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rsp_valid));
  a_r10_start_busy_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !req_valid) |=> !req_valid);
  a_r11_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(req_addr));

endmodule

// File: rtl/irq_remap_fetch.sv
module irq_remap_fetch
  import irq_remap_pkg::*;
#(
  parameter int unsigned PA_W     = 52,
  parameter int unsigned BASE_LSB = 6,
  parameter int unsigned IDX_W    = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_mode,
  input  logic            start,
  input  logic [63:0]     dte_word,
  input  logic [31:0]     msg_data,
  output logic            busy,
  output logic            req_valid,
  output logic [PA_W-1:0] req_addr,
  output logic            req_ext,
  input  logic            rsp_valid,
  input  logic [63:0]     rsp_data,
  input  logic            rsp_err,
  output logic            done,
  output logic [1:0]      status,
  output logic [2:0]      int_type,
  output logic [7:0]      vector,
  output logic            dest_mode,
  output logic            redir_hint,
  output logic [23:0]     dest
);

  logic            rst_meta_q, rst_sync_q;
  logic [PA_W-1:0] addr_calc;
  logic            dec_ext;
  logic [63:0]     dec_lo, dec_hi;
  rmp_status_e     dec_status, res_status;
  rmp_fields_t     dec_fields, res_fields;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  irq_remap_addr #(.PA_W(PA_W), .BASE_LSB(BASE_LSB), .IDX_W(IDX_W)) u_addr (
    .dte_word  (dte_word),
    .msg_data  (msg_data),
    .ext_mode  (ext_mode),
    .entry_addr(addr_calc)
  );

  irq_remap_ctrl #(.PA_W(PA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start     (start),
    .ext_mode  (ext_mode),
    .addr_in   (addr_calc),
    .busy      (busy),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_ext   (req_ext),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_err),
    .dec_ext   (dec_ext),
    .dec_lo    (dec_lo),
    .dec_hi    (dec_hi),
    .dec_status(dec_status),
    .dec_fields(dec_fields),
    .done      (done),
    .res_status(res_status),
    .res_fields(res_fields)
  );

  irq_remap_decode u_dec (
    .ext_mode  (dec_ext),
    .lo_half   (dec_lo),
    .hi_half   (dec_hi),
    .dec_status(dec_status),
    .dec_fields(dec_fields)
  );

  assign status     = res_status;
  assign int_type   = res_fields.int_type;
  assign vector     = res_fields.vector;
  assign dest_mode  = res_fields.dest_mode;
  assign redir_hint = res_fields.redir_hint;
  assign dest       = res_fields.dest;

  a_r2_ext_align: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (req_valid && req_ext) |-> (req_addr[3:0] == 4'd0));
  a_r2_cmp_align: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (req_valid && !req_ext) |-> (req_addr[1:0] == 2'd0));
  a_r8_ok_type: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (done && status == 2'd0) |-> (int_type <= 3'd1));
  a_r12_fail_zero: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (done && status != 2'd0) |-> (int_type == 3'd0 && vector == 8'd0 &&
                                  dest == 24'd0 && !dest_mode && !redir_hint));

endmodule

// File: tb/tb_irq_remap_fetch.sv
module tb_irq_remap_fetch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode = 1'b0;
  logic        start = 1'b0;
  logic [63:0] dte_word = '0;
  logic [31:0] msg_data = '0;
  logic        busy, req_valid, req_ext, done;
  logic [51:0] req_addr;
  logic        rsp_valid = 1'b0;
  logic [63:0] rsp_data = '0;
  logic        rsp_err = 1'b0;
  logic [1:0]  status;
  logic [2:0]  int_type;
  logic [7:0]  vector;
  logic        dest_mode, redir_hint;
  logic [23:0] dest;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  irq_remap_fetch dut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .start(start),
    .dte_word(dte_word), .msg_data(msg_data), .busy(busy),
    .req_valid(req_valid), .req_addr(req_addr), .req_ext(req_ext),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .done(done), .status(status), .int_type(int_type), .vector(vector),
    .dest_mode(dest_mode), .redir_hint(redir_hint), .dest(dest)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [51:0] exp_addr(input logic [63:0] d, input logic [31:0] m, input bit ext);
    logic [51:0] base;
    logic [51:0] idx;
    base = {d[51:6], 6'd0};
    idx  = {41'd0, m[10:0]};
    return base + (ext ? (idx << 4) : (idx << 2));
  endfunction

  // one lookup with fixed response timing
  task automatic run(input bit ext, input logic [63:0] dte, input logic [31:0] msg,
                     input logic [63:0] lo, input logic [63:0] hi,
                     input bit e0, input bit e1, input bit poke);
    logic [1:0]  st;
    logic [2:0]  ty;
    logic [7:0]  vec;
    logic [23:0] dst;
    logic        dm, rh;
    string       tg;
    logic [63:0] lo_eff;
    lo_eff = ext ? lo : {32'd0, lo[31:0]};
    ty = lo_eff[4:2]; rh = lo_eff[5]; dm = lo_eff[6];
    dst = ext ? lo_eff[31:8] : {16'd0, lo_eff[15:8]};
    vec = ext ? hi[7:0] : lo_eff[23:16];
    if (e0 || (ext && e1)) begin st = 2'd3; tg = "R9"; end
    else if (!lo_eff[0]) begin st = 2'd1; tg = "R6"; end
    else if (lo_eff[7]) begin st = 2'd2; tg = "R7"; end
    else if (ty > 3'd1) begin st = 2'd2; tg = "R8"; end
    else begin st = 2'd0; tg = ext ? "R5" : "R4"; end
    if (poke) tg = "R11";

    @(negedge clk);
    ext_mode = ext; dte_word = dte; msg_data = msg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin ext_mode = ~ext; msg_data = ~msg; dte_word = ~dte; end
    chk("R3 req_valid after start", {63'd0, req_valid}, 64'd1);
    chk("R2 req_addr", {12'd0, req_addr}, {12'd0, exp_addr(dte, msg, ext)});
    chk("R2 req_ext", {63'd0, req_ext}, {63'd0, ext});
    chk("R3 busy", {63'd0, busy}, 64'd1);
    if (poke) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(poke ? "R10 no second req" : "R3 req one cycle", {63'd0, req_valid}, 64'd0);
    rsp_valid = 1'b1; rsp_data = lo; rsp_err = e0;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_data = '0; rsp_err = 1'b0;
    if (ext && !e0) begin
      chk("R5 no done before high beat", {63'd0, done}, 64'd0);
      chk("R5 busy between beats", {63'd0, busy}, 64'd1);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_data = hi; rsp_err = e1;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_data = '0; rsp_err = 1'b0;
    end
    chk("R3 done", {63'd0, done}, 64'd1);
    chk("R3 busy low at done", {63'd0, busy}, 64'd0);
    chk({tg, " status"}, {62'd0, status}, {62'd0, st});
    if (st == 2'd0) begin
      chk({tg, " int_type"}, {61'd0, int_type}, {61'd0, ty});
      chk({tg, " vector"}, {56'd0, vector}, {56'd0, vec});
      chk({tg, " dest_mode"}, {63'd0, dest_mode}, {63'd0, dm});
      chk({tg, " redir_hint"}, {63'd0, redir_hint}, {63'd0, rh});
      chk({tg, " dest"}, {40'd0, dest}, {40'd0, dst});
    end else begin
      chk("R12 zero fields", {21'd0, int_type, vector, dest_mode, redir_hint, dest},
          64'd0);
    end
    @(negedge clk);
    chk("R3 done single", {63'd0, done}, 64'd0);
    chk(poke ? "R10 idle after poke" : "R3 idle", {62'd0, busy, req_valid}, 64'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] lo, hi;
    logic [63:0] dte;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", {63'd0, busy}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset outputs", {58'd0, busy, done, req_valid, status[1], status[0], |dest},
        64'd0);
    chk("R1 reset fields", {21'd0, int_type, vector, dest_mode, redir_hint, dest}, 64'd0);

    dte = 64'hFFF5_A5C3_1234_56BF;
    // R4..R8: every control byte in both formats
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 256; c++) begin
        lo = {32'hC0DE_0000 | 32'(c), 24'(c * 40503 + 17), 8'(c)};
        hi = {32'hFFFF_0000 | 32'(c * 3), 24'(c * 77), 8'(c * 13 + 5)};
        run(m[0], dte, 32'h0000_0400 | 32'(c * 5), lo, hi, 1'b0, 1'b0, 1'b0);
      end
    end
    // R2: index sweep with junk above the index field
    for (int i = 0; i < 64; i++) begin
      run(i[0], dte ^ 64'(i * 64'h0000_0133_0000_0041),
          32'hFFFF_F800 | 32'(i * 33), 64'h1, 64'h0, 1'b0, 1'b0, 1'b0);
    end
    run(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h7FF, 64'h1, 64'h0, 1'b0, 1'b0, 1'b0);
    run(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 32'h7FF, 64'h1, 64'h0, 1'b0, 1'b0, 1'b0);
    // R9: read failure on either beat
    run(1'b0, dte, 32'h12, 64'h0012_3401, 64'h0, 1'b1, 1'b0, 1'b0);
    run(1'b1, dte, 32'h34, 64'h0012_3401, 64'h77, 1'b1, 1'b0, 1'b0);
    run(1'b1, dte, 32'h56, 64'h0012_3401, 64'h77, 1'b0, 1'b1, 1'b0);
    // R10, R11: start while busy and inputs changed after start
    run(1'b0, dte, 32'h0000_0123, 64'hFFFF_FFFF_00AB_CD05, 64'h0000_0000_0000_0099,
        1'b0, 1'b0, 1'b1);
    run(1'b1, dte, 32'h0000_0321, 64'hFFFF_FFFF_00AB_CD05, 64'h0000_0000_0000_0099,
        1'b0, 1'b0, 1'b1);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule